// File: doc/BRIEF.md
# ATM Cell Slot Pace Scheduler

This block decides, once per transmit cell slot, which of a small set of virtual channels may send the next cell. A programmable slot timer fixes how often a slot opens, and so caps the total outgoing cell rate. The scheduler keeps a parameter table inside the block. Each entry holds an enable, a service class and, for constant-rate channels, a period measured in slots. When a slot opens, the block looks at the channels whose traffic request input is high and picks one of them. It then pulses a valid strobe together with the channel number. When no channel qualifies, it pulses an idle strobe instead.

Constant-rate (CBR) channels become due on a fixed slot cadence and always win over unspecified-rate (UBR) channels. UBR channels share the slots that remain, taking turns in round-robin order. Software writes the table and the timer through a one-cycle write port while the block runs. This lets it retune rates on the fly and so build an adaptive-rate service on top.

Top module: `atm_pace_sched`

## Requirements
- R1: While reset is asserted, and until the first slot opens afterwards, `slot_valid` and `slot_idle` are both low.
- R2: With timer value T, a decision pulse appears every T+1 clock cycles and at no other time. A decision pulse is one cycle of either `slot_valid` or `slot_idle`.
- R3: A timer write (`cfg_sel`=2, value in `cfg_data`) restarts the slot count and resets the round-robin position to channel 0. The first decision after it appears T+1 cycles after the write edge.
- R4: A decision pulse is never both valid and idle.
- R5: A slot with no eligible channel produces `slot_idle`.
- R6: A CBR channel with period P (`cfg_sel`=1) that is alone and always requesting is granted in the first slot after its configuration is written, and then every P slots.
- R7: A CBR channel that is due and requesting is granted ahead of any requesting UBR channel.
- R8: When several CBR channels are due in the same slot, the lowest-numbered one wins. The others stay due and are served in later slots, lowest first.
- R9: UBR channels are served round-robin. The search starts one channel past the last UBR grant and wraps from channel 7 to channel 0.
- R10: A channel is granted only in a slot where it is enabled and its `chan_req` bit is high.
- R11: Rewriting a channel's period or mode while the block runs restarts that channel's cadence. Its next due slot is the first slot after the write, and the new period applies from then on.
- R12: A mode write (`cfg_sel`=0) sets bit 0 = enable and bit 1 = class (1 = CBR, 0 = UBR). A period value of 0 behaves as 1, meaning due every slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target: 0 channel mode, 1 channel period, 2 slot timer |
| cfg_chan | input | 3 | Channel addressed by mode and period writes |
| cfg_data | input | 16 | Write data |
| chan_req | input | 8 | Per-channel pending-traffic flags |
| slot_valid | output | 1 | One-cycle pulse: a channel was chosen for this slot |
| slot_chan | output | 3 | Chosen channel, meaningful with `slot_valid` |
| slot_idle | output | 1 | One-cycle pulse: nothing eligible in this slot |

## Verification
The slot decision is registered, so a pulse appears in the cycle after the timer's terminal count. After a timer write at a clock edge, the first pulse is therefore due exactly T+1 cycles later, and each further pulse follows T+1 cycles after the one before. The bench stamps every pulse with a free-running cycle count taken at the falling edge. It discards pulses stamped at or before the write edge, then checks the first stamp and every gap against T+1. All table writes in a scenario finish before the first slot opens, so the expected grant order can be worked out slot by slot from the requirements. Mid-run rewrites and request changes are made two cycles after a pulse, well away from any slot boundary.

// File: rtl/atm_pace_pkg.sv
package atm_pace_pkg;

  typedef enum logic [1:0] {
    SEL_MODE   = 2'd0,
    SEL_PERIOD = 2'd1,
    SEL_TIMER  = 2'd2,
    SEL_NONE   = 2'd3
  } cfg_sel_e;

  localparam int MODE_EN_BIT  = 0;
  localparam int MODE_CBR_BIT = 1;

  typedef struct packed {
    logic en;
    logic cbr;
  } chan_mode_t;

endpackage

// File: rtl/aps_slot_timer.sv
module aps_slot_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          tick
);

  logic [TW-1:0] lim_q, lim_d;
  logic [TW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q >= lim_q);

  always_comb begin
    lim_d = lim_q;
    cnt_d = cnt_q;
    if (load) begin
      lim_d = load_val;
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= '0;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (load) begin
        lim_q <= lim_d;
      end
    end
  end

endmodule

// File: rtl/aps_chan_table.sv
module aps_chan_table
  import atm_pace_pkg::*;
#(
  parameter int NCH = 8,
  parameter int PW  = 16,
  parameter int IDW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           wr_mode,
  input  logic           wr_period,
  input  logic [IDW-1:0] wr_chan,
  input  logic [PW-1:0]  wr_data,
  input  logic [NCH-1:0] req,
  input  logic [NCH-1:0] grant_vec,
  output logic [NCH-1:0] cbr_elig,
  output logic [NCH-1:0] ubr_elig
);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    chan_mode_t    mode_q, mode_d;
    logic [PW-1:0] per_q, per_d;
    logic [PW-1:0] cd_q, cd_d;
    logic          due_q, due_d;
    logic          hit;
    logic          due_now;
    logic [PW-1:0] reload;

    assign hit     = (wr_chan == IDW'(g)) && (wr_mode || wr_period);
    assign due_now = mode_q.en && mode_q.cbr && (due_q || (cd_q == '0));
    assign reload  = (per_q == '0) ? '0 : per_q - 1'b1;

    assign cbr_elig[g] = due_now && req[g];
    assign ubr_elig[g] = mode_q.en && !mode_q.cbr && req[g];

    always_comb begin
      mode_d = mode_q;
      per_d  = per_q;
      cd_d   = cd_q;
      due_d  = due_q;
      if (hit) begin
        if (wr_mode) begin
          mode_d.en  = wr_data[MODE_EN_BIT];
          mode_d.cbr = wr_data[MODE_CBR_BIT];
        end
        if (wr_period) begin
          per_d = wr_data;
        end
        cd_d  = '0;
        due_d = 1'b0;
      end else if (!mode_q.en || !mode_q.cbr) begin
        due_d = 1'b0;
      end else if (tick) begin
        cd_d  = (cd_q == '0) ? reload : cd_q - 1'b1;
        due_d = due_now && !grant_vec[g];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q <= '0;
        per_q  <= '0;
        cd_q   <= '0;
        due_q  <= 1'b0;
      end else begin
        mode_q <= mode_d;
        per_q  <= per_d;
        cd_q   <= cd_d;
        due_q  <= due_d;
      end
    end
  end

endmodule

// File: rtl/aps_arbiter.sv
module aps_arbiter #(
  parameter int NCH = 8,
  parameter int IDW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           rr_clear,
  input  logic [NCH-1:0] cbr_elig,
  input  logic [NCH-1:0] ubr_elig,
  output logic [NCH-1:0] grant_vec,
  output logic [IDW-1:0] grant_id,
  output logic           grant_any
);

  logic [IDW-1:0] ptr_q, ptr_d;
  logic           cbr_hit, ubr_hit;
  logic [IDW-1:0] cbr_id, ubr_id;

  always_comb begin
    cbr_hit = 1'b0;
    cbr_id  = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (cbr_elig[i]) begin
        cbr_hit = 1'b1;
        cbr_id  = IDW'(i);
      end
    end
  end

  always_comb begin
    int idx;
    ubr_hit = 1'b0;
    ubr_id  = '0;
    for (int k = 0; k < NCH; k++) begin
      idx = int'(ptr_q) + k;
      if (idx >= NCH) begin
        idx = idx - NCH;
      end
      if (!ubr_hit && ubr_elig[idx]) begin
        ubr_hit = 1'b1;
        ubr_id  = IDW'(idx);
      end
    end
  end

  assign grant_any = cbr_hit || ubr_hit;
  assign grant_id  = cbr_hit ? cbr_id : ubr_id;
  assign grant_vec = (tick && grant_any) ? (NCH'(1) << grant_id) : '0;

  always_comb begin
    ptr_d = ptr_q;
    if (rr_clear) begin
      ptr_d = '0;
    end else if (tick && !cbr_hit && ubr_hit) begin
      ptr_d = (int'(ubr_id) == NCH - 1) ? '0 : ubr_id + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else begin
      ptr_q <= ptr_d;
    end
  end

endmodule

// File: rtl/atm_pace_sched.sv
module atm_pace_sched
  import atm_pace_pkg::*;
#(
  parameter int NCH = 8,
  parameter int PW  = 16,
  parameter int IDW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [1:0]     cfg_sel,
  input  logic [IDW-1:0] cfg_chan,
  input  logic [PW-1:0]  cfg_data,
  input  logic [NCH-1:0] chan_req,
  output logic           slot_valid,
  output logic [IDW-1:0] slot_chan,
  output logic           slot_idle
);

  logic [1:0]     rst_pipe;
  logic           rst_sync_n;
  logic           wr_mode, wr_period, wr_timer;
  logic           tick;
  logic [NCH-1:0] cbr_elig, ubr_elig, grant_vec;
  logic [IDW-1:0] grant_id;
  logic           grant_any;
  logic           valid_q, valid_d, idle_q, idle_d;
  logic [IDW-1:0] chan_q, chan_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  assign wr_mode   = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_MODE);
  assign wr_period = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_PERIOD);
  assign wr_timer  = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_TIMER);

  aps_slot_timer #(.TW(PW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (wr_timer),
    .load_val (cfg_data),
    .tick     (tick)
  );

  aps_chan_table #(.NCH(NCH), .PW(PW), .IDW(IDW)) u_table (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick      (tick),
    .wr_mode   (wr_mode),
    .wr_period (wr_period),
    .wr_chan   (cfg_chan),
    .wr_data   (cfg_data),
    .req       (chan_req),
    .grant_vec (grant_vec),
    .cbr_elig  (cbr_elig),
    .ubr_elig  (ubr_elig)
  );

  aps_arbiter #(.NCH(NCH), .IDW(IDW)) u_arb (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick      (tick),
    .rr_clear  (wr_timer),
    .cbr_elig  (cbr_elig),
    .ubr_elig  (ubr_elig),
    .grant_vec (grant_vec),
    .grant_id  (grant_id),
    .grant_any (grant_any)
  );

  always_comb begin
    valid_d = 1'b0;
    idle_d  = 1'b0;
    chan_d  = '0;
    if (tick) begin
      valid_d = grant_any;
      idle_d  = !grant_any;
      chan_d  = grant_any ? grant_id : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      idle_q  <= 1'b0;
      chan_q  <= '0;
    end else begin
      valid_q <= valid_d;
      idle_q  <= idle_d;
      chan_q  <= chan_d;
    end
  end

  assign slot_valid = valid_q;
  assign slot_idle  = idle_q;
  assign slot_chan  = chan_q;

endmodule

// File: rtl/aps_sva.sv
module aps_sva #(
  parameter int NCH = 8,
  parameter int IDW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick,
  input logic [NCH-1:0] req,
  input logic [NCH-1:0] cbr_elig,
  input logic [NCH-1:0] ubr_elig,
  input logic [IDW-1:0] grant_id,
  input logic           grant_any,
  input logic           slot_valid,
  input logic           slot_idle
);

  // R4
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_valid && slot_idle));

  // R2
  pulse_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid || slot_idle) |-> $past(tick));

  // R2
  tick_yields_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (slot_valid || slot_idle));

  // R10
  grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && grant_any) |-> req[grant_id]);

  // R7
  cbr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (|cbr_elig)) |-> cbr_elig[grant_id]);

  // R5
  idle_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !(|cbr_elig) && !(|ubr_elig)) |=> slot_idle);

endmodule

bind atm_pace_sched aps_sva #(.NCH(NCH), .IDW(IDW)) u_sva (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .tick       (tick),
  .req        (chan_req),
  .cbr_elig   (cbr_elig),
  .ubr_elig   (ubr_elig),
  .grant_id   (grant_id),
  .grant_any  (grant_any),
  .slot_valid (slot_valid),
  .slot_idle  (slot_idle)
);

// File: tb/tb_atm_pace_sched.sv
`timescale 1ns/100ps
module tb_atm_pace_sched;

  localparam int NCH  = 8;
  localparam int IDLE = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [1:0] cfg_sel;
  logic [2:0] cfg_chan;
  logic [15:0] cfg_data;
  logic [7:0] chan_req;
  logic       slot_valid, slot_idle;
  logic [2:0] slot_chan;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int t0 = 0;
  int n_log = 0;
  bit log_en = 0;
  int log_code [64];
  int log_cyc  [64];

  always #2.5 clk = ~clk;

  atm_pace_sched dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_chan(cfg_chan), .cfg_data(cfg_data), .chan_req(chan_req),
    .slot_valid(slot_valid), .slot_chan(slot_chan), .slot_idle(slot_idle)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (log_en && cyc > t0 && (slot_valid || slot_idle) && n_log < 64) begin
      log_code[n_log] = slot_valid ? int'(slot_chan) : IDLE;
      log_cyc[n_log]  = cyc;
      n_log++;
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [1:0] sel, input int ch, input int data);
    @(negedge clk);
    cfg_we   = 1'b1;
    cfg_sel  = sel;
    cfg_chan = 3'(ch);
    cfg_data = 16'(data);
    @(posedge clk);
    #1 cfg_we = 1'b0;
  endtask

  task automatic wait_ev(input int n);
    while (n_log < n) @(negedge clk);
  endtask

  task automatic ev_is(input int i, input int exp, input string rq);
    chk(log_code[i] == exp, rq, log_code[i], exp);
  endtask

  // clear all channels, then load the timer and open a fresh log
  task automatic prepare(input int tper);
    log_en = 0;
    for (int c = 0; c < NCH; c++) cfg_wr(2'd0, c, 0);
    chan_req = 8'hFF;
    cfg_wr(2'd2, 0, tper);
    t0 = cyc;
    n_log = 0;
    log_en = 1;
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    cfg_we = 1'b0; cfg_sel = '0; cfg_chan = '0; cfg_data = '0; chan_req = '0;
    repeat (4) @(negedge clk);
    chk(slot_valid == 1'b0, "R1 valid in reset", slot_valid, 0);
    chk(slot_idle == 1'b0, "R1 idle in reset", slot_idle, 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!slot_valid && !slot_idle, "R1 quiet after release", slot_valid | slot_idle, 0);
    repeat (6) @(negedge clk);
  endtask

  task automatic test_timer_idle();
    prepare(5);
    wait_ev(4);
    chk(log_cyc[0] == t0 + 6, "R3 first slot delay", log_cyc[0] - t0, 6);
    for (int i = 1; i < 4; i++)
      chk(log_cyc[i] - log_cyc[i-1] == 6, "R2 slot spacing", log_cyc[i] - log_cyc[i-1], 6);
    for (int i = 0; i < 4; i++) ev_is(i, IDLE, "R5 idle with no channel");
  endtask

  task automatic test_cbr_alone();
    int exp [7] = '{2, IDLE, IDLE, 2, IDLE, IDLE, 2};
    prepare(7);
    cfg_wr(2'd1, 2, 3);
    cfg_wr(2'd0, 2, 3);   // R12: enable + CBR
    wait_ev(7);
    for (int i = 0; i < 7; i++) ev_is(i, exp[i], "R6 CBR cadence");
  endtask

  task automatic test_mix();
    int exp [8] = '{5, 1, 5, 6, 5, 1, 5, 6};
    prepare(9);
    chan_req = 8'hFF & ~8'h08;   // channel 3 not requesting (R10)
    cfg_wr(2'd1, 5, 2);
    cfg_wr(2'd0, 5, 3);
    cfg_wr(2'd0, 1, 1);   // UBR
    cfg_wr(2'd0, 6, 1);
    cfg_wr(2'd0, 3, 1);
    wait_ev(8);
    for (int i = 0; i < 8; i++) ev_is(i, exp[i], "R7 R9 R10 CBR first, UBR rotation");
  endtask

  task automatic test_collide();
    int exp [8] = '{0, 4, IDLE, IDLE, 0, 4, IDLE, IDLE};
    prepare(7);
    cfg_wr(2'd1, 0, 4);
    cfg_wr(2'd1, 4, 4);
    cfg_wr(2'd0, 4, 3);
    cfg_wr(2'd0, 0, 3);
    wait_ev(8);
    for (int i = 0; i < 8; i++) ev_is(i, exp[i], "R8 CBR collision order");
  endtask

  task automatic test_rewrite();
    int exp [8] = '{2, IDLE, 2, 2, IDLE, IDLE, IDLE, 2};
    prepare(7);
    cfg_wr(2'd1, 2, 2);
    cfg_wr(2'd0, 2, 3);
    wait_ev(3);
    cfg_wr(2'd1, 2, 4);   // R11 mid-run period change
    wait_ev(8);
    for (int i = 0; i < 8; i++) ev_is(i, exp[i], "R11 runtime period rewrite");
    chk(log_cyc[7] - log_cyc[6] == 8, "R2 spacing kept", log_cyc[7] - log_cyc[6], 8);
  endtask

  task automatic test_zero_period();
    prepare(4);
    cfg_wr(2'd1, 7, 0);
    cfg_wr(2'd0, 7, 3);
    wait_ev(3);
    for (int i = 0; i < 3; i++) ev_is(i, 7, "R12 period zero every slot");
    @(negedge clk);
    chan_req[7] = 1'b0;
    wait_ev(5);
    ev_is(3, IDLE, "R10 no grant without request");
    ev_is(4, IDLE, "R10 no grant without request");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    test_reset();
    test_timer_idle();
    test_cbr_alone();
    test_mix();
    test_collide();
    test_rewrite();
    test_zero_period();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule